// File: doc/BRIEF.md
# Backplane Command Cycle Sequencer

This block runs one complete command cycle on a crate backplane each time a start request arrives. The request gives a 5-bit station number, a 4-bit subaddress, a 5-bit function code and 24 bits of write data. The sequencer drives the station, subaddress and function lines and waits a settling interval. It then raises the first strobe, during which read data and the two module response bits are captured. The second strobe follows. After that the sequencer releases every backplane line and waits a dead time. Only then does it pulse `done` and present the captured results.

Every phase length is a parameter counted in clock cycles. The function code decides the transfer direction. Codes 0 to 7 read from the module. Codes 16 to 23 write to the module. All other codes move no data. A requester holds off while `busy` is high. A start request given during a cycle has no effect.

Top module: `bp_cycle_seq`

## Requirements
- R1: After reset, `busy`, `done`, both strobes, all backplane address, function and write-data lines, and all result outputs are 0.
- R2: A start accepted at a clock edge drives `bp_stn`, `bp_sub` and `bp_fn` from the next cycle onward, and they hold those values unchanged until the second strobe ends. The first strobe rises after exactly SETTLE_CLKS cycles of selection.
- R3: `bp_s1` stays high for exactly S1_CLKS cycles. `bp_s2` rises in the cycle right after `bp_s1` falls. The two strobes are never high together.
- R4: `bp_s2` stays high for exactly S2_CLKS cycles.
- R5: When `bp_s2` falls, all station, subaddress, function and write-data lines go to 0 and stay there for exactly DEAD_CLKS cycles. `done` is then high for one cycle.
- R6: On a read (function code 0 to 7), `rsp_rdata` returns the value of `bp_rdata` sampled in the first cycle of `bp_s1`. Data presented at other times is not used. The result changes only when `done` is high.
- R7: On a write (function code 16 to 23), `bp_wdata` carries the request's write data from selection through the end of `bp_s2`. On any other code, `bp_wdata` stays 0.
- R8: `rsp_q` and `rsp_x` return `bp_q` and `bp_x` as sampled in the first cycle of `bp_s1`, and are updated together with `done`.
- R9: `busy` is high from the cycle after an accepted start until `done`, and is low while `done` is high. A start request while `busy` is high changes no output and produces no extra `done`.
- R10: For function codes that are neither reads nor writes (8 to 15, 24 to 31), `rsp_rdata` returns 0 and `bp_wdata` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, taken when idle |
| cmd_stn | input | 5 | Requested station number |
| cmd_sub | input | 4 | Requested subaddress |
| cmd_fn | input | 5 | Requested function code |
| cmd_wdata | input | 24 | Write data for write codes |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 24 | Captured read data (0 on non-reads) |
| rsp_q | output | 1 | Captured Q response |
| rsp_x | output | 1 | Captured X response |
| bp_stn | output | 5 | Backplane station lines |
| bp_sub | output | 4 | Backplane subaddress lines |
| bp_fn | output | 5 | Backplane function lines |
| bp_wdata | output | 24 | Backplane write-data lines |
| bp_s1 | output | 1 | First strobe |
| bp_s2 | output | 1 | Second strobe |
| bp_rdata | input | 24 | Read data from the module |
| bp_q | input | 1 | Q response from the module |
| bp_x | input | 1 | X response from the module |

## Verification
The hardest condition to reach from the ports is proving that the results come from the first strobe cycle and from no other time. The bench's module model therefore returns valid read data and the true Q value only while `bp_s1` is high, and the complemented or all-ones values otherwise. A capture that happens too early or too late then shows up as a wrong result. A second hard case is a start request that arrives mid-cycle carrying a different command. The bench raises one partway through a cycle and checks that the lines keep their values and that no extra `done` appears.

// File: rtl/bp_cycle_pkg.sv
package bp_cycle_pkg;

    localparam int STN_W  = 5;
    localparam int SUB_W  = 4;
    localparam int FN_W   = 5;
    localparam int DATA_W = 24;

    localparam logic [FN_W-1:0] RD_LO = 5'd0;
    localparam logic [FN_W-1:0] RD_HI = 5'd7;
    localparam logic [FN_W-1:0] WR_LO = 5'd16;
    localparam logic [FN_W-1:0] WR_HI = 5'd23;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEL,
        PH_S1,
        PH_S2,
        PH_DEAD
    } phase_e;

endpackage

// File: rtl/bp_fn_class.sv
module bp_fn_class
    import bp_cycle_pkg::*;
(
    input  logic [FN_W-1:0] fn,
    output logic            is_read,
    output logic            is_write
);

    always_comb begin
        is_read  = (fn >= RD_LO) && (fn <= RD_HI);
        is_write = (fn >= WR_LO) && (fn <= WR_HI);
    end

    always_comb begin
        assert (!(is_read && is_write)) else $error("p_class_excl_r10");
    end

endmodule

// File: rtl/bp_phase_timer.sv
module bp_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/bp_cycle_seq.sv
module bp_cycle_seq
    import bp_cycle_pkg::*;
#(
    parameter int SETTLE_CLKS = 10,
    parameter int S1_CLKS     = 10,
    parameter int S2_CLKS     = 5,
    parameter int DEAD_CLKS   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [STN_W-1:0]  cmd_stn,
    input  logic [SUB_W-1:0]  cmd_sub,
    input  logic [FN_W-1:0]   cmd_fn,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_q,
    output logic              rsp_x,
    output logic [STN_W-1:0]  bp_stn,
    output logic [SUB_W-1:0]  bp_sub,
    output logic [FN_W-1:0]   bp_fn,
    output logic [DATA_W-1:0] bp_wdata,
    output logic              bp_s1,
    output logic              bp_s2,
    input  logic [DATA_W-1:0] bp_rdata,
    input  logic              bp_q,
    input  logic              bp_x
);

    localparam int MAX_A   = (SETTLE_CLKS > S1_CLKS) ? SETTLE_CLKS : S1_CLKS;
    localparam int MAX_B   = (S2_CLKS > DEAD_CLKS) ? S2_CLKS : DEAD_CLKS;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CLKS - 1);
    localparam logic [CNT_W-1:0] S1_LD     = CNT_W'(S1_CLKS - 1);
    localparam logic [CNT_W-1:0] S2_LD     = CNT_W'(S2_CLKS - 1);
    localparam logic [CNT_W-1:0] DEAD_LD   = CNT_W'(DEAD_CLKS - 1);

    typedef struct packed {
        phase_e              phase;
        logic [STN_W-1:0]    stn;
        logic [SUB_W-1:0]    sub;
        logic [FN_W-1:0]     fn;
        logic [DATA_W-1:0]   wdata;
        logic                s1;
        logic                s2;
        logic                busy;
        logic                done;
        logic                rd;
        logic                armed;
        logic [DATA_W-1:0]   cap_rdata;
        logic                cap_q;
        logic                cap_x;
        logic [DATA_W-1:0]   out_rdata;
        logic                out_q;
        logic                out_x;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             cls_read;
    logic             cls_write;

    bp_fn_class u_fn_class (
        .fn       (cmd_fn),
        .is_read  (cls_read),
        .is_write (cls_write)
    );

    bp_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;

        if (st_q.armed && st_q.phase == PH_S1) begin
            st_d.armed     = 1'b0;
            st_d.cap_rdata = st_q.rd ? bp_rdata : '0;
            st_d.cap_q     = bp_q;
            st_d.cap_x     = bp_x;
        end

        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_SEL;
                    st_d.stn   = cmd_stn;
                    st_d.sub   = cmd_sub;
                    st_d.fn    = cmd_fn;
                    st_d.wdata = cls_write ? cmd_wdata : '0;
                    st_d.rd    = cls_read;
                    st_d.busy  = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = SETTLE_LD;
                end
            end
            PH_SEL: begin
                if (tmr_expired) begin
                    st_d.phase = PH_S1;
                    st_d.s1    = 1'b1;
                    st_d.armed = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = S1_LD;
                end
            end
            PH_S1: begin
                if (tmr_expired) begin
                    st_d.phase = PH_S2;
                    st_d.s1    = 1'b0;
                    st_d.s2    = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = S2_LD;
                end
            end
            PH_S2: begin
                if (tmr_expired) begin
                    st_d.phase = PH_DEAD;
                    st_d.s2    = 1'b0;
                    st_d.stn   = '0;
                    st_d.sub   = '0;
                    st_d.fn    = '0;
                    st_d.wdata = '0;
                    tmr_load   = 1'b1;
                    tmr_val    = DEAD_LD;
                end
            end
            PH_DEAD: begin
                if (tmr_expired) begin
                    st_d.phase     = PH_IDLE;
                    st_d.busy      = 1'b0;
                    st_d.done      = 1'b1;
                    st_d.out_rdata = st_q.cap_rdata;
                    st_d.out_q     = st_q.cap_q;
                    st_d.out_x     = st_q.cap_x;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign rsp_rdata = st_q.out_rdata;
    assign rsp_q     = st_q.out_q;
    assign rsp_x     = st_q.out_x;
    assign bp_stn    = st_q.stn;
    assign bp_sub    = st_q.sub;
    assign bp_fn     = st_q.fn;
    assign bp_wdata  = st_q.wdata;
    assign bp_s1     = st_q.s1;
    assign bp_s2     = st_q.s2;

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bp_s1 && bp_s2));

    p_s2_follows_s1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bp_s2) |-> $past(bp_s1));

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bp_s2) |-> (bp_stn == '0 && bp_sub == '0 && bp_fn == '0 && bp_wdata == '0));

    p_done_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_lines_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_s1 || bp_s2) |-> (busy && $stable(bp_stn) && $stable(bp_sub) && $stable(bp_fn)));

    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rsp_rdata) && $stable(rsp_q) && $stable(rsp_x)));

    p_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(bp_fn >= WR_LO && bp_fn <= WR_HI)) |-> (bp_wdata == '0));

endmodule

// File: tb/test_bp_cycle_seq.sv
`timescale 1ns/1ps
module test_bp_cycle_seq;

    localparam int SETTLE = 10;
    localparam int S1N    = 10;
    localparam int S2N    = 5;
    localparam int DEADN  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  cmd_stn = '0;
    logic [3:0]  cmd_sub = '0;
    logic [4:0]  cmd_fn = '0;
    logic [23:0] cmd_wdata = '0;
    logic        busy, done, rsp_q, rsp_x, bp_s1, bp_s2;
    logic [23:0] rsp_rdata, bp_wdata, bp_rdata;
    logic [4:0]  bp_stn, bp_fn;
    logic [3:0]  bp_sub;
    logic        bp_q, bp_x;
    logic        mod_q = 1'b0, mod_x = 1'b0;

    always #4 clk = ~clk;

    // module model: valid values only while the first strobe is high
    assign bp_rdata = bp_s1 ? {bp_stn, bp_sub, bp_fn, 10'h2A5} : 24'hFFFFFF;
    assign bp_q     = bp_s1 ? mod_q : ~mod_q;
    assign bp_x     = bp_s1 ? mod_x : ~mod_x;

    bp_cycle_seq i_bp_cycle_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmd_stn(cmd_stn), .cmd_sub(cmd_sub), .cmd_fn(cmd_fn), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rsp_rdata(rsp_rdata), .rsp_q(rsp_q), .rsp_x(rsp_x),
        .bp_stn(bp_stn), .bp_sub(bp_sub), .bp_fn(bp_fn), .bp_wdata(bp_wdata),
        .bp_s1(bp_s1), .bp_s2(bp_s2), .bp_rdata(bp_rdata), .bp_q(bp_q), .bp_x(bp_x)
    );

    typedef struct {
        logic [4:0]  stn;
        logic [3:0]  sub;
        logic [4:0]  fn;
        logic [23:0] w;
        logic [23:0] rd;
        logic        q;
        logic        x;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   done_seen = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor
    int  n_sel = 0, n_s1 = 0, n_s2 = 0, n_dead = 0;
    bit  after_s2 = 0, line_bad = 0;
    always @(negedge clk) begin
        if (rst_n && busy) begin
            if (exp_q.size() == 0) begin
                chk(0, "R9", "busy without request", 32'd1, 32'd0);
            end else begin
                if (bp_s1) begin
                    n_s1++;
                    if (bp_stn != exp_q[0].stn || bp_sub != exp_q[0].sub ||
                        bp_fn != exp_q[0].fn || bp_wdata != exp_q[0].w) line_bad = 1;
                end else if (bp_s2) begin
                    n_s2++; after_s2 = 1;
                    if (bp_stn != exp_q[0].stn || bp_sub != exp_q[0].sub ||
                        bp_fn != exp_q[0].fn || bp_wdata != exp_q[0].w) line_bad = 1;
                end else if (after_s2) begin
                    n_dead++;
                    if (bp_stn != 0 || bp_sub != 0 || bp_fn != 0 || bp_wdata != 0) line_bad = 1;
                end else begin
                    n_sel++;
                    if (bp_stn != exp_q[0].stn || bp_sub != exp_q[0].sub ||
                        bp_fn != exp_q[0].fn || bp_wdata != exp_q[0].w) line_bad = 1;
                end
            end
        end
        if (rst_n && done) begin
            done_seen++;
            if (exp_q.size() == 0) begin
                chk(0, "R9", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(!busy, "R9", "busy during done", busy, 0);
                chk(n_sel == SETTLE, "R2", "selection length", n_sel, SETTLE);
                chk(n_s1 == S1N, "R3", "S1 length", n_s1, S1N);
                chk(n_s2 == S2N, "R4", "S2 length", n_s2, S2N);
                chk(n_dead == DEADN, "R5", "dead length", n_dead, DEADN);
                chk(!line_bad, "R7", "line values over cycle (R2/R5)", line_bad, 0);
                chk(rsp_rdata == e.rd, "R6", "read data (R10 for no-data)", rsp_rdata, e.rd);
                chk(rsp_q == e.q && rsp_x == e.x, "R8", "q/x", {rsp_q, rsp_x}, {e.q, e.x});
            end
            n_sel = 0; n_s1 = 0; n_s2 = 0; n_dead = 0; after_s2 = 0; line_bad = 0;
        end
    end

    function automatic bit is_rd(input logic [4:0] f);
        return f <= 5'd7;
    endfunction
    function automatic bit is_wr(input logic [4:0] f);
        return f >= 5'd16 && f <= 5'd23;
    endfunction

    // driver: one cycle, optional mid-cycle start to be ignored
    task automatic run(input logic [4:0] n, input logic [3:0] a, input logic [4:0] f,
                       input logic [23:0] w, input logic q, input logic x, input bit poke);
        exp_t e;
        e.stn = n; e.sub = a; e.fn = f;
        e.w  = is_wr(f) ? w : 24'h0;
        e.rd = is_rd(f) ? {n, a, f, 10'h2A5} : 24'h0;
        e.q  = q; e.x = x;
        exp_q.push_back(e);
        @(negedge clk);
        mod_q = q; mod_x = x;
        cmd_stn = n; cmd_sub = a; cmd_fn = f; cmd_wdata = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cmd_stn = ~n; cmd_sub = ~a; cmd_fn = ~f; cmd_wdata = ~w;
        if (poke) begin
            repeat (13) @(negedge clk);
            start = 1'b1;   // R9: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    int wd = 0;
    always @(negedge clk) begin
        wd++;
        if (wd > 100000) begin
            chk(0, "R9", "watchdog expired", wd, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !bp_s1 && !bp_s2, "R1", "control outputs",
            {busy, done, bp_s1, bp_s2}, 0);
        chk(bp_stn == 0 && bp_sub == 0 && bp_fn == 0 && bp_wdata == 0, "R1", "bus lines",
            {bp_stn, bp_sub, bp_fn}, 0);
        chk(rsp_rdata == 0 && !rsp_q && !rsp_x, "R1", "results", rsp_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(5'd3, 4'd2, 5'd0, 24'h123456, 1'b1, 1'b1, 0);   // R6 read
        run(5'd24, 4'd15, 5'd7, 24'h0, 1'b0, 1'b1, 0);      // R6 read, top code
        run(5'd9, 4'd1, 5'd16, 24'hABCDEF, 1'b1, 1'b0, 0);  // R7 write
        run(5'd1, 4'd0, 5'd23, 24'h5A5A5A, 1'b0, 1'b0, 0);  // R7 write, top code
        run(5'd7, 4'd4, 5'd8, 24'hFFFFFF, 1'b1, 1'b1, 0);   // R10 no data
        run(5'd30, 4'd9, 5'd24, 24'h00F00F, 1'b0, 1'b1, 0); // R10 no data
        run(5'd12, 4'd6, 5'd15, 24'h111111, 1'b1, 1'b0, 0); // R10 no data
        run(5'd5, 4'd3, 5'd2, 24'h0, 1'b1, 1'b1, 1);        // R9 start while busy
        run(5'd17, 4'd12, 5'd18, 24'hC0FFEE, 1'b0, 1'b0, 1);// R9 start while busy, write

        repeat (40) @(negedge clk);
        // R9: ignored starts made no extra cycle
        chk(done_seen == 9, "R9", "done count", done_seen, 9);
        chk(!busy && exp_q.size() == 0, "R9", "idle after run", busy, 0);
        chk(bp_stn == 0 && bp_wdata == 0 && !bp_s1 && !bp_s2, "R5", "lines released at idle",
            bp_stn, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule